// File: doc/BRIEF.md
# Phase-Synchronised Centre-Aligned PWM Timebase

This block generates one centre-aligned PWM output from a counter that climbs from zero to a programmable period and then falls back to zero, so one output cycle spans twice the period in counted ticks. The counter moves only on cycles where the tick enable is high. An output edge is produced where the counter meets an active compare value. The output rises on a match while rising and falls on a match while falling. The compare value is double-buffered: the input acts as the shadow value, and the active copy changes only at the bottom of the count.

Several instances can be chained with fixed phase offsets. A master runs with phase loading off and sends a sync pulse out each time its counter reaches zero. Each follower has phase loading on. On a sync pulse it jumps its counter to a programmed phase value and is told whether to continue upward or downward from there. It also forwards the sync pulse unchanged to the next instance. A one-cycle interrupt pulse marks every arrival at zero. There are no streaming data paths. All pins are plain control and status levels or pulses.

Top module: `ud_pwm_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, count_o is 0 and pwm_a_o, zero_irq_o and sync_out_o are 0.
- R2: On each cycle with tick_en_i high, and with no sync load, the counter steps by one. It rises from 0 to period_i and then falls to 0, so a full cycle is 2*period_i ticks. With tick_en_i low, the counter holds.
- R3: On every clock, pwm_a_o is registered from the state before the edge. When the count equals the active compare value after an upward step, or after a sync load with the up direction, pwm_a_o becomes 1. When it equals that value after a downward step, pwm_a_o becomes 0. Otherwise it holds.
- R4: The active compare value takes cmp_a_i only on a ticked cycle while the count is 0. A change to cmp_a_i at any other time takes effect only from the next pass through zero.
- R5: On a ticked cycle with sync_in_i and phase_load_en_i both high, the counter loads the phase value instead of stepping. After the load it continues upward if sync_dir_up_i was 1, and downward if it was 0.
- R6: With phase_load_en_i low, sync_in_i has no effect on the count.
- R7: A phase_i above period_i is loaded as period_i.
- R8: With sync_out_zero_i at 0, sync_out_o follows sync_in_i in the same cycle.
- R9: With sync_out_zero_i at 1, sync_out_o is a one-clock pulse in the cycle after the counter becomes 0.
- R10: zero_irq_o is a one-clock pulse in the cycle after each tick that leaves the counter at 0, and count_o is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Counter advance enable |
| period_i | input | W | Top of the up-down count |
| cmp_a_i | input | W | Compare shadow value |
| phase_i | input | W | Value loaded on sync |
| phase_load_en_i | input | 1 | 1: sync reloads the counter |
| sync_dir_up_i | input | 1 | Direction after a sync load (1 up, 0 down) |
| sync_out_zero_i | input | 1 | 0: pass sync in through; 1: pulse at zero |
| sync_in_i | input | 1 | Single-cycle sync pulse |
| pwm_a_o | output | 1 | Raw PWM A output |
| sync_out_o | output | 1 | Sync to the next instance |
| zero_irq_o | output | 1 | Zero-count interrupt pulse |
| count_o | output | W | Current timebase count |

## Verification
The bench goes after the turn points of the count. A design that turns a cycle early or late at the period or at zero shows a wrong count and a cycle length other than 2*period. The bench also changes the compare value in mid-cycle. A design without the double buffer would move the output edge inside the current cycle instead of the next one. It also sends sync pulses with loading off, with a phase above the period, and with each direction setting. A design that ignored the enable, skipped the clamp or kept its old direction would land on a different count. The bench also runs with an irregular tick enable, to catch a counter that steps on plain clocks.

// File: rtl/udp_pkg.sv
package udp_pkg;
  // Direction of the step that produced the present count.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/udp_counter.sv
module udp_counter
  import udp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] prd,
  input  logic [W-1:0] phase,
  input  logic         ph_en,
  input  logic         sync_in,
  input  logic         sync_up,
  output logic [W-1:0] cnt_q,
  output dir_e         dir_q,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] phase_c;
  logic [W-1:0] step_cnt;
  dir_e         step_dir;
  dir_e         dir_d;
  logic         do_load;

  // phase clamp (R7)
  always_comb begin
    phase_c = (phase > prd) ? prd : phase;
  end

  // normal up-down step (R2)
  always_comb begin
    step_cnt = cnt_q;
    step_dir = dir_q;
    if (dir_q == DIR_UP) begin
      if (cnt_q >= prd) begin
        step_cnt = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
        step_dir = DIR_DOWN;
      end else begin
        step_cnt = cnt_q + ONE;
      end
    end else begin
      if (cnt_q == ZERO) begin
        step_cnt = (prd == ZERO) ? ZERO : ONE;
        step_dir = DIR_UP;
      end else begin
        step_cnt = cnt_q - ONE;
      end
    end
  end

  // sync load has priority over the step (R5, R6)
  always_comb begin
    do_load = sync_in && ph_en;
    if (!tick) begin
      cnt_nxt = cnt_q;
      dir_d   = dir_q;
    end else if (do_load) begin
      cnt_nxt = phase_c;
      dir_d   = sync_up ? DIR_UP : DIR_DOWN;
    end else begin
      cnt_nxt = step_cnt;
      dir_d   = step_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= DIR_DOWN;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/udp_compare.sv
module udp_compare
  import udp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  dir_e         dir,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] act_q,
  output logic         pwm_q
);
  logic take;
  logic hit;

  always_comb begin
    take = tick && (cnt == '0);
    hit  = (cnt == act_q);
  end

  // double buffer: copy at the bottom of the count (R4)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (take) begin
      act_q <= shadow;
    end
  end

  // action on compare match (R3)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (hit) begin
      pwm_q <= (dir == DIR_UP);
    end
  end
endmodule

// File: rtl/udp_sync.sv
module udp_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_nxt,
  input  logic         zero_mode,
  input  logic         sync_in,
  output logic         zevt_q,
  output logic         sync_out
);
  // zero event pulse (R9, R10)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zevt_q <= 1'b0;
    end else begin
      zevt_q <= tick && (cnt_nxt == '0);
    end
  end

  // output select (R8, R9)
  always_comb begin
    sync_out = zero_mode ? zevt_q : sync_in;
  end
endmodule

// File: rtl/ud_pwm_core.sv
module ud_pwm_core
  import udp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] phase_i,
  input  logic         phase_load_en_i,
  input  logic         sync_dir_up_i,
  input  logic         sync_out_zero_i,
  input  logic         sync_in_i,
  output logic         pwm_a_o,
  output logic         sync_out_o,
  output logic         zero_irq_o,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  dir_e         dir_q;
  logic [W-1:0] cmp_act;
  logic         zevt;

  udp_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en_i),
    .prd     (period_i),
    .phase   (phase_i),
    .ph_en   (phase_load_en_i),
    .sync_in (sync_in_i),
    .sync_up (sync_dir_up_i),
    .cnt_q   (cnt_q),
    .dir_q   (dir_q),
    .cnt_nxt (cnt_nxt)
  );

  udp_compare #(.W(W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en_i),
    .cnt    (cnt_q),
    .dir    (dir_q),
    .shadow (cmp_a_i),
    .act_q  (cmp_act),
    .pwm_q  (pwm_a_o)
  );

  udp_sync #(.W(W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en_i),
    .cnt_nxt   (cnt_nxt),
    .zero_mode (sync_out_zero_i),
    .sync_in   (sync_in_i),
    .zevt_q    (zevt),
    .sync_out  (sync_out_o)
  );

  assign zero_irq_o = zevt;
  assign count_o    = cnt_q;
endmodule

// File: rtl/udp_checker.sv
module udp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] prd,
  input logic [W-1:0] phase,
  input logic         ph_en,
  input logic         sync_in,
  input logic [W-1:0] count,
  input logic         pwm,
  input logic         irq,
  input logic [W-1:0] cmp_act
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(sync_in && ph_en) && count != '0 && count < prd)
    |=> (count == W'($past(count) + 1'b1) || count == W'($past(count) - 1'b1)));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sync_in && ph_en && phase <= prd) |=> count == $past(phase));

  p_irq_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count == '0);

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && prd != '0) |=> !irq);

  p_pwm_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> $past(count) == $past(cmp_act));

  p_pwm_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm) |-> $past(count) == $past(cmp_act));
endmodule

bind ud_pwm_core udp_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_en_i),
  .prd     (period_i),
  .phase   (phase_i),
  .ph_en   (phase_load_en_i),
  .sync_in (sync_in_i),
  .count   (count_o),
  .pwm     (pwm_a_o),
  .irq     (zero_irq_o),
  .cmp_act (cmp_act)
);

// File: tb/sim_ud_pwm_core.sv
module sim_ud_pwm_core;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en_i = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] cmp_a_i = '0;
  logic [W-1:0] phase_i = '0;
  logic         phase_load_en_i = 1'b0;
  logic         sync_dir_up_i = 1'b0;
  logic         sync_out_zero_i = 1'b1;
  logic         sync_in_i = 1'b0;
  logic         pwm_a_o, sync_out_o, zero_irq_o;
  logic [W-1:0] count_o;

  ud_pwm_core #(.W(W)) u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [W-1:0] cnt;
    logic         pwm;
    logic         z;
    logic         so;
    logic         zmode;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  string scen = "reset";
  bit done = 1'b0;

  // reference state, derived from the requirements
  logic [W-1:0] m_cnt = '0;
  logic         m_up = 1'b0;
  logic [W-1:0] m_cmp = '0;
  logic         m_pwm = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] got %0d expected %0d", tag, scen, got, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic cyc(input logic tk, input logic sy);
    exp_t e;
    logic [W-1:0] ph;
    @(negedge clk);
    tick_en_i = tk;
    sync_in_i = sy;
    e.pwm = (m_cnt == m_cmp) ? m_up : m_pwm;
    e.z = 1'b0;
    if (tk) begin
      if (m_cnt == 0) m_cmp = cmp_a_i;
      if (sy && phase_load_en_i) begin
        ph = (phase_i > period_i) ? period_i : phase_i;
        m_cnt = ph;
        m_up = sync_dir_up_i;
      end else if (m_up) begin
        if (m_cnt >= period_i) begin
          m_cnt = (m_cnt == 0) ? '0 : m_cnt - 1'b1;
          m_up = 1'b0;
        end else m_cnt = m_cnt + 1'b1;
      end else begin
        if (m_cnt == 0) begin
          m_cnt = (period_i == 0) ? '0 : W'(1);
          m_up = 1'b1;
        end else m_cnt = m_cnt - 1'b1;
      end
      e.z = (m_cnt == 0);
    end
    m_pwm = e.pwm;
    e.cnt = m_cnt;
    e.zmode = sync_out_zero_i;
    e.so = sync_out_zero_i ? e.z : sy;
    q.push_back(e);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2", int'(count_o), int'(e.cnt));
        chk("R3", int'(pwm_a_o), int'(e.pwm));
        chk("R10", int'(zero_irq_o), int'(e.z));
        if (e.zmode) chk("R9", int'(sync_out_o), int'(e.so));
        else         chk("R8", int'(sync_out_o), int'(e.so));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    period_i = 16'd6;
    cmp_a_i = 16'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(count_o), 0);
    chk("R1", int'(pwm_a_o), 0);
    chk("R1", int'(zero_irq_o), 0);
    chk("R1", int'(sync_out_o), 0);

    scen = "R2 R3 free run";
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0);

    scen = "R2 sparse tick";
    for (int i = 0; i < 40; i++) cyc(i % 3 != 1, 1'b0);

    scen = "R4 shadow change mid-cycle";
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
    cmp_a_i = 16'd5;
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);

    scen = "R6 sync ignored";
    phase_load_en_i = 1'b0;
    phase_i = 16'd1;
    for (int i = 0; i < 12; i++) cyc(1'b1, i == 3 || i == 8);

    scen = "R5 R8 load up";
    sync_out_zero_i = 1'b0;
    phase_load_en_i = 1'b1;
    phase_i = 16'd3;
    sync_dir_up_i = 1'b1;
    for (int i = 0; i < 20; i++) cyc(1'b1, i == 2 || i == 13);

    scen = "R5 load down";
    sync_dir_up_i = 1'b0;
    phase_i = 16'd4;
    for (int i = 0; i < 20; i++) cyc(1'b1, i == 5 || i == 14);

    scen = "R7 clamp";
    phase_i = 16'd20;
    sync_dir_up_i = 1'b1;
    for (int i = 0; i < 16; i++) cyc(1'b1, i == 4);

    scen = "R9 R3 compare at period and zero";
    sync_out_zero_i = 1'b1;
    phase_load_en_i = 1'b0;
    cmp_a_i = 16'd6;
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);
    cmp_a_i = 16'd0;
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0);

    scen = "R2 longer period";
    period_i = 16'd10;
    cmp_a_i = 16'd7;
    for (int i = 0; i < 60; i++) cyc(i % 2 == 0, 1'b0);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule